// File: doc/BRIEF.md
# Line-Control Serial Transmitter

This block turns bytes into asynchronous serial frames. An 8-bit line control word sets the whole frame. It selects the word length, the stop length and the parity mode, and it can force a break. A tick input pulses sixteen times per bit period, and every bit time and stop time is counted in these ticks. Bytes enter a single holding register through a valid/ready handshake. A shift stage then sends them. Two status outputs report when the holding register is free and when the whole transmitter is idle.

An optional clear-to-send gate holds back the start of each new character until the far end is ready. The frame settings are captured when a byte moves from the holding register into the shifter. A change to the control word therefore applies to the next character. Break is the exception: it acts in the same clock cycle.

The controller has six states:

| State | Action | Leaves to |
|---|---|---|
| IDLE | line at mark | START when the holding register is full and the gate allows; the byte and its settings are loaded |
| START | one spacing bit | DATA after 16 ticks |
| DATA | bits sent LSB first | PARITY or STOP after the last bit |
| PARITY | parity bit | STOP after 16 ticks |
| STOP | mark for the stop length | IDLE |
| BREAK | line held spacing | IDLE as soon as break clears |

Any state goes to BREAK while the break bit is set.

Top module: `lcw_uart_tx`

## Requirements
- R1: Each frame starts with one start bit at 0, followed by the data bits LSB first, with each bit lasting 16 ticks. Control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent.
- R2: The stop period is at mark (1). With control bit 2 at 0 it lasts 16 ticks. With bit 2 at 1 it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. A byte waiting in the holding register starts right after the stop period, with no extra tick of mark.
- R3: With control bit 3 at 1, a parity bit of 16 ticks is sent between the last data bit and the stop period. With bit 3 at 0 no parity bit is sent.
- R4: With parity on and control bit 5 at 0, bit 4 at 1 selects even parity and bit 4 at 0 selects odd parity, both counted over the sent data bits.
- R5: With parity on and control bit 5 at 1, the parity bit is the inverse of control bit 4. Bit 4 at 0 gives mark (1) and bit 4 at 1 gives space (0).
- R6: While control bit 6 is 1, txd is 0 in the same cycle, including during a character already in progress. A character cut off by break is dropped. Once bit 6 clears, txd returns to 1 and the dropped character does not resume.
- R7: hold_empty (equal to in_ready) is 1 while the holding register is free, including while a character is still shifting. tx_empty is 1 only when both the holding register and the shifter are idle.
- R8: With cts_gate_en at 1, no new character starts while cts is 0, and the byte stays in the holding register. With cts_gate_en at 0, cts has no effect.
- R9: After reset, txd is 1 and hold_empty, tx_empty and in_ready are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick16 | input | 1 | one-cycle pulse, 16 per bit time |
| line_ctrl | input | 8 | line control word |
| cts_gate_en | input | 1 | enables the clear-to-send gate on character start |
| cts | input | 1 | clear to send, active high |
| in_data | input | DATA_W | byte to send |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | holding register can take a byte |
| txd | output | 1 | serial line, idle at 1 |
| hold_empty | output | 1 | holding register free |
| tx_empty | output | 1 | holding register and shifter both idle |

## Verification
Break and an in-flight character can meet in one cycle. The control word sets break while the shifter sits in the middle of a data bit. The bench samples txd one step after that edge and expects 0 at once. It then holds break across many ticks and expects no mark sample. After break clears, it expects txd at 1 and tx_empty at 1, with no resumed frame. Back-to-back characters put the end of one stop period and the load of the next byte close together. The bench checks these by an exact tick count of the stop run before the following start bit.

// File: rtl/lcw_uart_pkg.sv
package lcw_uart_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_e;
endpackage

// File: rtl/lcw_hold.sv
module lcw_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              take,
    output logic [DATA_W-1:0] rd_data,
    output logic              full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            rd_data <= '0;
        end else if (wr_valid && !full) begin
            full    <= 1'b1;
            rd_data <= wr_data;
        end else if (take) begin
            full    <= 1'b0;
        end
    end

    assign wr_ready = !full;
endmodule

// File: rtl/lcw_frame_cfg.sv
module lcw_frame_cfg #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic [7:0]                             ctrl,
    input  logic [DATA_W-1:0]                      raw,
    output logic [DATA_W-1:0]                      masked,
    output logic [$clog2(DATA_W+1)-1:0]            nbits,
    output logic                                   par_en,
    output logic                                   par_bit,
    output logic [$clog2(2*TICKS_PER_BIT+1)-1:0]   stop_ticks
);
    localparam int BIT_W = $clog2(DATA_W+1);
    localparam int CNT_W = $clog2(2*TICKS_PER_BIT+1);
    localparam int MIN_BITS = DATA_W - 3;

    logic ones;

    assign nbits = BIT_W'(MIN_BITS) + BIT_W'(ctrl[1:0]);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = raw[i] & (BIT_W'(i) < nbits);
    end

    assign ones    = ^masked;
    assign par_en  = ctrl[3];
    assign par_bit = ctrl[5] ? ~ctrl[4] : (ctrl[4] ? ones : ~ones);

    always_comb begin
        if (!ctrl[2])
            stop_ticks = CNT_W'(TICKS_PER_BIT);
        else if (nbits == BIT_W'(MIN_BITS))
            stop_ticks = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT/2);
        else
            stop_ticks = CNT_W'(2*TICKS_PER_BIT);
    end
endmodule

// File: rtl/lcw_uart_tx.sv
module lcw_uart_tx
    import lcw_uart_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [7:0]        line_ctrl,
    input  logic              cts_gate_en,
    input  logic              cts,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    localparam int BIT_W = $clog2(DATA_W+1);
    localparam int CNT_W = $clog2(2*TICKS_PER_BIT+1);

    tx_state_e          st, st_nx;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bidx;
    logic [DATA_W-1:0]  shreg;
    logic [BIT_W-1:0]   cur_nbits;
    logic               cur_pen, cur_par;
    logic [CNT_W-1:0]   cur_stop;

    logic               hold_full, load, brk, can_go, tick_end, stop_end, line;
    logic [DATA_W-1:0]  hold_data, fr_data;
    logic [BIT_W-1:0]   fr_nbits;
    logic               fr_pen, fr_par;
    logic [CNT_W-1:0]   fr_stop;

    lcw_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (in_valid),
        .wr_data  (in_data),
        .wr_ready (in_ready),
        .take     (load),
        .rd_data  (hold_data),
        .full     (hold_full)
    );

    lcw_frame_cfg #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_cfg (
        .ctrl       (line_ctrl),
        .raw        (hold_data),
        .masked     (fr_data),
        .nbits      (fr_nbits),
        .par_en     (fr_pen),
        .par_bit    (fr_par),
        .stop_ticks (fr_stop)
    );

    assign brk      = line_ctrl[6];
    assign can_go   = hold_full && (!cts_gate_en || cts);
    assign tick_end = tick16 && (cnt == CNT_W'(TICKS_PER_BIT-1));
    assign stop_end = tick16 && (cnt == cur_stop - 1'b1);
    assign load     = (st == ST_IDLE) && !brk && can_go;

    // next-state logic
    always_comb begin
        st_nx = st;
        if (brk) begin
            st_nx = ST_BREAK;
        end else begin
            unique case (st)
                ST_IDLE:   if (can_go)   st_nx = ST_START;
                ST_START:  if (tick_end) st_nx = ST_DATA;
                ST_DATA:   if (tick_end && bidx == cur_nbits - 1'b1)
                               st_nx = cur_pen ? ST_PARITY : ST_STOP;
                ST_PARITY: if (tick_end) st_nx = ST_STOP;
                ST_STOP:   if (stop_end) st_nx = ST_IDLE;
                ST_BREAK:  st_nx = ST_IDLE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // shifter and tick counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            cur_nbits <= '0;
            cur_pen   <= 1'b0;
            cur_par   <= 1'b0;
            cur_stop  <= '0;
        end else if (load) begin
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= fr_data;
            cur_nbits <= fr_nbits;
            cur_pen   <= fr_pen;
            cur_par   <= fr_par;
            cur_stop  <= fr_stop;
        end else if (tick16 && st != ST_IDLE && st != ST_BREAK) begin
            if ((st == ST_STOP) ? stop_end : tick_end) cnt <= '0;
            else                                       cnt <= cnt + 1'b1;
            if (st == ST_DATA && tick_end) begin
                shreg <= shreg >> 1;
                bidx  <= bidx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = cur_par;
            ST_STOP:   line = 1'b1;
            ST_BREAK:  line = 1'b0;
            default:   line = 1'b1;
        endcase
        txd        = line & ~brk;
        hold_empty = !hold_full;
        tx_empty   = (st == ST_IDLE || st == ST_BREAK) && !hold_full;
    end
endmodule

// File: rtl/lcw_uart_tx_chk.sv
module lcw_uart_tx_chk
    import lcw_uart_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] line_ctrl,
    input logic       cts_gate_en,
    input logic       cts,
    input logic       in_valid,
    input logic       in_ready,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty,
    input tx_state_e  st
);
    a_r6_break_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !txd);

    a_r1_start_space: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> !txd);

    a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !hold_empty);

    a_r7_empty_chain: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    a_r8_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cts_gate_en && !cts) |=> (st != ST_START));

    a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !line_ctrl[6]) |-> txd);
endmodule

bind lcw_uart_tx lcw_uart_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_ctrl   (line_ctrl),
    .cts_gate_en (cts_gate_en),
    .cts         (cts),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .tx_empty    (tx_empty),
    .st          (st)
);

// File: tb/sim_lcw_uart_tx.sv
`timescale 1ns/1ps
module sim_lcw_uart_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic [1:0] tdiv;
    logic [7:0] line_ctrl = 8'h03;
    logic       cts_gate_en = 1'b0;
    logic       cts = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, txd, hold_empty, tx_empty;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pen;
        bit         pb;
        int         stp;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdiv   <= 2'd0;
            tick16 <= 1'b0;
        end else begin
            tdiv   <= tdiv + 2'd1;
            tick16 <= (tdiv == 2'd3);
        end
    end

    lcw_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctrl(line_ctrl),
        .cts_gate_en(cts_gate_en), .cts(cts), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tk(output logic v);
        do @(negedge clk); while (!tick16);
        v = txd;
    endtask

    task automatic tickwait(int n);
        repeat (n) begin
            do @(negedge clk); while (!tick16);
        end
    endtask

    task automatic put(logic [7:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // driver: expected frame from the requirements, then the byte
    task automatic send(logic [7:0] d);
        exp_t e;
        logic [7:0] md;
        bit ones;
        e.nb  = 5 + int'(line_ctrl[1:0]);
        md    = d & 8'((1 << e.nb) - 1);
        ones  = ^md;
        e.d   = md;
        e.pen = line_ctrl[3];
        e.pb  = line_ctrl[5] ? ~line_ctrl[4] : (line_ctrl[4] ? ones : ~ones);
        e.stp = !line_ctrl[2] ? 16 : (e.nb == 5 ? 24 : 32);
        q.push_back(e);
        put(d);
    endtask

    task automatic drain();
        while (q.size() != 0 || !tx_empty) @(negedge clk);
        tickwait(60);
    endtask

    task automatic pair(logic [7:0] c, logic [7:0] b1, logic [7:0] b2);
        line_ctrl = c;
        send(b1);
        tickwait(3);
        check(hold_empty == 1'b1, "R7 holding free while shifting", hold_empty, 1);
        check(tx_empty == 1'b0, "R7 not empty while shifting", tx_empty, 0);
        send(b2);
        check(hold_empty == 1'b0, "R7 holding full after accept", hold_empty, 0);
        drain();
    endtask

    // monitor: rebuild frames from tick samples, compare with the queue
    initial begin : monitor
        logic v;
        int ones, pstop;
        bit pend;
        exp_t e;
        ones = 0; pstop = 0; pend = 1'b0;
        @(posedge rst_n);
        forever begin
            tk(v);
            if (!mon_on) begin
                ones = 0; pend = 1'b0;
            end else if (v) begin
                ones++;
                if (pend && ones == 48) begin
                    check(ones >= pstop, "R2 stop run", ones, pstop);
                    pend = 1'b0;
                end
            end else begin
                if (pend) check(ones == pstop, "R2 stop length", ones, pstop);
                pend = 1'b0;
                ones = 0;
                for (int i = 2; i <= 16; i++) begin
                    tk(v);
                    if (i == 8) check(v == 1'b0, "R1 start bit", v, 0);
                end
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected frame", 1, 0);
                end else begin
                    e = q.pop_front();
                    for (int b = 0; b < e.nb; b++) begin
                        for (int i = 1; i <= 16; i++) begin
                            tk(v);
                            if (i == 8) check(v == e.d[b], "R1 data bit", v, e.d[b]);
                        end
                    end
                    if (e.pen) begin
                        for (int i = 1; i <= 16; i++) begin
                            tk(v);
                            if (i == 8) check(v == e.pb, "R3 parity bit (R4 even/odd, R5 stick)", v, e.pb);
                        end
                    end
                    pend  = 1'b1;
                    pstop = e.stp;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cnt1;
        logic v;
        repeat (5) @(negedge clk);
        check(txd == 1'b1, "R9 reset txd", txd, 1);
        check(hold_empty == 1'b1, "R9 reset hold_empty", hold_empty, 1);
        check(tx_empty == 1'b1, "R9 reset tx_empty", tx_empty, 1);
        check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        repeat (4) @(negedge clk);

        pair(8'h03, 8'hA5, 8'h3C);   // R1 8 bits, one stop, no parity
        pair(8'h04, 8'h13, 8'hFF);   // R2 5 bits, 1.5 stop
        pair(8'h1E, 8'h41, 8'h7F);   // R4 7 bits, even, two stop
        pair(8'h09, 8'h2A, 8'h15);   // R4 6 bits, odd
        pair(8'h0F, 8'hC1, 8'h80);   // R2 8 bits, odd, two stop
        pair(8'h2B, 8'h00, 8'h81);   // R5 stick mark
        pair(8'h3B, 8'hFF, 8'h12);   // R5 stick space

        // R8: gate closed holds the character back
        line_ctrl   = 8'h03;
        cts_gate_en = 1'b1;
        cts         = 1'b0;
        send(8'h5A);
        cnt1 = 0;
        for (int i = 0; i < 40; i++) begin
            tk(v);
            if (!v) cnt1++;
        end
        check(cnt1 == 0, "R8 no start while cts low", cnt1, 0);
        check(hold_empty == 1'b0, "R8 byte kept in holding register", hold_empty, 0);
        cts = 1'b1;
        drain();
        cts_gate_en = 1'b0;
        cts         = 1'b0;

        // R6: break over a character in flight
        mon_on = 1'b0;
        tickwait(2);
        put(8'hC3);
        tickwait(40);
        @(negedge clk);
        line_ctrl = 8'h43;
        #1;
        check(txd == 1'b0, "R6 break same cycle", txd, 0);
        cnt1 = 0;
        for (int i = 0; i < 40; i++) begin
            tk(v);
            if (v) cnt1++;
        end
        check(cnt1 == 0, "R6 continuous spacing", cnt1, 0);
        @(negedge clk);
        line_ctrl = 8'h03;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R6 mark after break", txd, 1);
        check(tx_empty == 1'b1, "R6 interrupted character dropped", tx_empty, 1);
        cnt1 = 0;
        for (int i = 0; i < 200; i++) begin
            tk(v);
            if (!v) cnt1++;
        end
        check(cnt1 == 0, "R6 no resumed frame", cnt1, 0);

        mon_on = 1'b1;
        tickwait(2);
        pair(8'h03, 8'h99, 8'h66);   // R1 recovery after break

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule